// File: doc/BRIEF.md
# Banked Control Register File

This block holds the control registers of a small processor core together with the general register that the core uses as its stack pointer. The status word is assembled from six separate flag bits. Two stack pointers are kept: one for interrupt context and one for user context. The live stack-pointer register always carries the one that the stack-mode flag selects, and the other waits in its own storage. When a status-word write changes the stack mode, the block exchanges the two values on the same clock edge.

Three ports reach the state. The control port reads and writes control registers by a small index. The stack-pointer port reads and writes the live stack-pointer register. A flat debug port takes one number that names a general register, a control register, the program counter or one half of the accumulator. Registers held here are served locally. For registers held elsewhere, the debug port returns data supplied from outside and raises a write strobe. The stack mode is a two-state machine. In state STK_INTR (stack-mode 0) the interrupt pointer is live. In state STK_USER (stack-mode 1) the user pointer is live. Transition SWAP_TO_USER is taken on a status write with bit 7 set while in STK_INTR. Transition SWAP_TO_INTR is taken on a status write with bit 7 clear while in STK_USER. Any other cycle keeps the state.

Top module: `sysreg_bank`

## Requirements
- R1: After reset every flag is 0, the mode is STK_INTR (stack-mode 0), and every control register index and the stack-pointer port read 0.
- R2: Control register 0 reads the status word: condition at bit 0, interrupt-enable at bit 6, stack-mode at bit 7, backup condition at bit 8, backup interrupt-enable at bit 14, backup stack-mode at bit 15, and 0 in all other bits. A write loads all six flags from those bit positions.
- R3: Control register 1 reads the condition flag in bit 0 and 0 in all other bits. A write to it changes only the condition flag, taken from bit 0.
- R4: Control register 2 (interrupt stack pointer) reads and writes the live stack-pointer register while stack-mode is 0, and its own storage while stack-mode is 1.
- R5: Control register 3 (user stack pointer) reads and writes the live stack-pointer register while stack-mode is 1, and its own storage while stack-mode is 0.
- R6: A status write that changes stack-mode from 0 to 1 saves the live value into interrupt storage and loads the live register from user storage. A change from 1 to 0 saves the live value into user storage and loads the live register from interrupt storage.
- R7: A status write that leaves stack-mode unchanged exchanges nothing.
- R8: Control registers 4, 5 and 6 (6 being the backup PC) are plain 32-bit storage.
- R9: Control indices 7 to 15 read 0, and writes to them change nothing.
- R10: When a stack-pointer port write falls in the same cycle as a status write that flips stack-mode, the exchange wins and the port write is dropped.
- R11: Every read is combinational and returns the value from before any write in that cycle. Writes take effect at the rising clock edge.
- R12: Debug numbers 0 to 14 return the external general-register data and put the number on the general-register select. Number 15 returns the live stack pointer. Numbers 16 to 20 return control registers 0 to 4. Number 21 returns the PC input. Number 22 returns accumulator bits 31:0 and number 23 returns bits 63:32. All other numbers return 0 and raise no strobe.
- R13: A debug write goes to a local register only when the primary port for that register is idle in that cycle: the control port for numbers 16 to 20, the stack-pointer port for number 15. For numbers 0 to 14, 21, 22 and 23, a debug write raises exactly one matching external write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cr_idx | input | 4 | Control register index |
| cr_we | input | 1 | Control register write enable |
| cr_wdata | input | 32 | Control register write data |
| cr_rdata | output | 32 | Control register read data |
| sp_we | input | 1 | Stack-pointer register write enable |
| sp_wdata | input | 32 | Stack-pointer register write data |
| sp_rdata | output | 32 | Live stack-pointer register value |
| dbg_num | input | 5 | Flat debug register number |
| dbg_we | input | 1 | Debug write enable |
| dbg_wdata | input | 32 | Debug write data, also used by outside targets |
| dbg_rdata | output | 32 | Debug read data |
| gr_ext_rdata | input | 32 | Read data of the outside general register chosen by dbg_gr_num |
| pc_val | input | 32 | Current program counter |
| acc_val | input | 64 | Current accumulator |
| dbg_gr_num | output | 4 | General register number for the outside file |
| gr_ext_we | output | 1 | Debug write strobe for outside general registers 0 to 14 |
| pc_we | output | 1 | Debug write strobe for the program counter |
| accl_we | output | 1 | Debug write strobe for accumulator bits 31:0 |
| acch_we | output | 1 | Debug write strobe for accumulator bits 63:32 |

## Verification
The hardest case to reach from the ports is a mode flip that lands in the same cycle as a write to the live stack pointer, whether from the stack-pointer port, the debug port, or both. The bank then has to ignore the new value and save the old one. Directed steps set up distinct values in both stored pointers, then flip the mode with a colliding write in each direction. A fixed-seed random phase also issues status writes with a random bit 7 while most cycles carry stack-pointer and debug writes, so collisions and no-flip status writes happen often.

// File: rtl/sbk_pkg.sv
package sbk_pkg;

    // Status word bit positions (software-visible layout)
    localparam int unsigned PSW_C   = 0;
    localparam int unsigned PSW_IE  = 6;
    localparam int unsigned PSW_SM  = 7;
    localparam int unsigned PSW_BC  = 8;
    localparam int unsigned PSW_BIE = 14;
    localparam int unsigned PSW_BSM = 15;

    // Control register indices with special meaning
    localparam int unsigned CRI_PSW   = 0;
    localparam int unsigned CRI_COND  = 1;
    localparam int unsigned CRI_ISP   = 2;
    localparam int unsigned CRI_USP   = 3;
    localparam int unsigned CRI_PLAIN = 4;

    // Flat debug numbering
    localparam int unsigned NUM_GR       = 16;
    localparam int unsigned SP_GR        = 15;
    localparam int unsigned DBG_CR_BASE  = 16;
    localparam int unsigned DBG_CR_CNT   = 5;
    localparam int unsigned DBG_PC       = 21;
    localparam int unsigned DBG_ACC_LO   = 22;
    localparam int unsigned DBG_ACC_HI   = 23;

    typedef enum logic {
        STK_INTR = 1'b0,
        STK_USER = 1'b1
    } stk_mode_e;

    typedef enum logic [2:0] {
        DK_NONE,
        DK_GR,
        DK_CR,
        DK_PC,
        DK_ACCL,
        DK_ACCH
    } dbg_kind_e;

    typedef struct packed {
        logic bsm;
        logic bie;
        logic bc;
        logic ie;
        logic c;
    } flag_s;

endpackage

// File: rtl/sbk_flags.sv
module sbk_flags
    import sbk_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psw_we,
    input  logic              cond_we,
    input  logic [DATA_W-1:0] wdata,
    output flag_s             flags
);

    flag_s flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (psw_we) begin
            flags_q.bsm <= wdata[PSW_BSM];
            flags_q.bie <= wdata[PSW_BIE];
            flags_q.bc  <= wdata[PSW_BC];
            flags_q.ie  <= wdata[PSW_IE];
            flags_q.c   <= wdata[PSW_C];
        end else if (cond_we) begin
            flags_q.c   <= wdata[0];
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/sbk_stack_bank.sv
module sbk_stack_bank
    import sbk_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psw_we,
    input  logic              new_sm,
    input  logic              isp_we,
    input  logic              usp_we,
    input  logic [DATA_W-1:0] cr_wdata,
    input  logic              sp_we,
    input  logic [DATA_W-1:0] sp_wdata,
    output stk_mode_e         mode,
    output logic [DATA_W-1:0] live_sp,
    output logic [DATA_W-1:0] isp_view,
    output logic [DATA_W-1:0] usp_view,
    output logic [DATA_W-1:0] isp_raw,
    output logic [DATA_W-1:0] usp_raw
);

    stk_mode_e         state_q, state_d;
    logic [DATA_W-1:0] live_q, live_d;
    logic [DATA_W-1:0] isp_q, isp_d;
    logic [DATA_W-1:0] usp_q, usp_d;

    // Next-state: transitions SWAP_TO_USER and SWAP_TO_INTR
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STK_INTR: if (psw_we && new_sm)  state_d = STK_USER;
            STK_USER: if (psw_we && !new_sm) state_d = STK_INTR;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= STK_INTR;
        else        state_q <= state_d;
    end

    // Data path: port write, then aliased control write, then exchange
    always_comb begin
        live_d = live_q;
        isp_d  = isp_q;
        usp_d  = usp_q;
        if (sp_we) live_d = sp_wdata;
        unique case (state_q)
            STK_INTR: begin
                if (isp_we) live_d = cr_wdata;
                if (usp_we) usp_d  = cr_wdata;
                if (state_d == STK_USER) begin
                    isp_d  = live_q;
                    live_d = usp_q;
                end
            end
            STK_USER: begin
                if (usp_we) live_d = cr_wdata;
                if (isp_we) isp_d  = cr_wdata;
                if (state_d == STK_INTR) begin
                    usp_d  = live_q;
                    live_d = isp_q;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            isp_q  <= '0;
            usp_q  <= '0;
        end else begin
            live_q <= live_d;
            isp_q  <= isp_d;
            usp_q  <= usp_d;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            STK_INTR: begin
                isp_view = live_q;
                usp_view = usp_q;
            end
            STK_USER: begin
                isp_view = isp_q;
                usp_view = live_q;
            end
        endcase
    end

    assign mode    = state_q;
    assign live_sp = live_q;
    assign isp_raw = isp_q;
    assign usp_raw = usp_q;

endmodule

// File: rtl/sbk_plain_store.sv
module sbk_plain_store #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NUM    = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM-1:0]            we,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NUM-1:0][DATA_W-1:0] q
);

    for (genvar i = 0; i < NUM; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q[i] <= '0;
            else if (we[i]) q[i] <= wdata;
        end
    end

endmodule

// File: rtl/sbk_dbg_decode.sv
module sbk_dbg_decode
    import sbk_pkg::*;
#(
    parameter int unsigned DBG_W    = 5,
    parameter int unsigned CR_IDX_W = 4
) (
    input  logic [DBG_W-1:0]    num,
    output dbg_kind_e           kind,
    output logic [3:0]          gr_num,
    output logic [CR_IDX_W-1:0] cr_sel
);

    always_comb begin
        kind   = DK_NONE;
        gr_num = num[3:0];
        cr_sel = '0;
        if (num < DBG_W'(NUM_GR)) begin
            kind = DK_GR;
        end else if (num < DBG_W'(DBG_CR_BASE + DBG_CR_CNT)) begin
            kind   = DK_CR;
            cr_sel = CR_IDX_W'(num - DBG_W'(DBG_CR_BASE));
        end else if (num == DBG_W'(DBG_PC)) begin
            kind = DK_PC;
        end else if (num == DBG_W'(DBG_ACC_LO)) begin
            kind = DK_ACCL;
        end else if (num == DBG_W'(DBG_ACC_HI)) begin
            kind = DK_ACCH;
        end
    end

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sbk_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CR_IDX_W  = 4,
    parameter int unsigned DBG_W     = 5,
    parameter int unsigned NUM_PLAIN = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CR_IDX_W-1:0] cr_idx,
    input  logic                cr_we,
    input  logic [DATA_W-1:0]   cr_wdata,
    output logic [DATA_W-1:0]   cr_rdata,
    input  logic                sp_we,
    input  logic [DATA_W-1:0]   sp_wdata,
    output logic [DATA_W-1:0]   sp_rdata,
    input  logic [DBG_W-1:0]    dbg_num,
    input  logic                dbg_we,
    input  logic [DATA_W-1:0]   dbg_wdata,
    output logic [DATA_W-1:0]   dbg_rdata,
    input  logic [DATA_W-1:0]   gr_ext_rdata,
    input  logic [DATA_W-1:0]   pc_val,
    input  logic [2*DATA_W-1:0] acc_val,
    output logic [3:0]          dbg_gr_num,
    output logic                gr_ext_we,
    output logic                pc_we,
    output logic                accl_we,
    output logic                acch_we
);

    localparam int unsigned NUM_CR = CRI_PLAIN + NUM_PLAIN;

    dbg_kind_e           dbg_kind;
    logic [CR_IDX_W-1:0] dbg_cr_sel;
    logic                dbg_sp_hit;
    logic                eff_cr_we;
    logic [CR_IDX_W-1:0] eff_cr_idx;
    logic [DATA_W-1:0]   eff_cr_wd;
    logic                eff_sp_we;
    logic [DATA_W-1:0]   eff_sp_wd;
    flag_s               flags;
    stk_mode_e           mode;
    logic                mode_user;
    logic [DATA_W-1:0]   live_sp, isp_view, usp_view, bank_isp, bank_usp;
    logic [NUM_PLAIN-1:0]             plain_we;
    logic [NUM_PLAIN-1:0][DATA_W-1:0] plain_q;
    logic [DATA_W-1:0]   cr_view [NUM_CR];
    logic [DATA_W-1:0]   dbg_cr_data;

    sbk_dbg_decode #(.DBG_W(DBG_W), .CR_IDX_W(CR_IDX_W)) u_dec (
        .num    (dbg_num),
        .kind   (dbg_kind),
        .gr_num (dbg_gr_num),
        .cr_sel (dbg_cr_sel)
    );

    // Primary ports win over the debug port
    assign dbg_sp_hit = (dbg_kind == DK_GR) && (dbg_gr_num == 4'(SP_GR));
    assign eff_cr_we  = cr_we | (dbg_we & (dbg_kind == DK_CR));
    assign eff_cr_idx = cr_we ? cr_idx   : dbg_cr_sel;
    assign eff_cr_wd  = cr_we ? cr_wdata : dbg_wdata;
    assign eff_sp_we  = sp_we | (dbg_we & dbg_sp_hit);
    assign eff_sp_wd  = sp_we ? sp_wdata : dbg_wdata;

    sbk_flags #(.DATA_W(DATA_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .psw_we  (eff_cr_we && eff_cr_idx == CR_IDX_W'(CRI_PSW)),
        .cond_we (eff_cr_we && eff_cr_idx == CR_IDX_W'(CRI_COND)),
        .wdata   (eff_cr_wd),
        .flags   (flags)
    );

    sbk_stack_bank #(.DATA_W(DATA_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .psw_we   (eff_cr_we && eff_cr_idx == CR_IDX_W'(CRI_PSW)),
        .new_sm   (eff_cr_wd[PSW_SM]),
        .isp_we   (eff_cr_we && eff_cr_idx == CR_IDX_W'(CRI_ISP)),
        .usp_we   (eff_cr_we && eff_cr_idx == CR_IDX_W'(CRI_USP)),
        .cr_wdata (eff_cr_wd),
        .sp_we    (eff_sp_we),
        .sp_wdata (eff_sp_wd),
        .mode     (mode),
        .live_sp  (live_sp),
        .isp_view (isp_view),
        .usp_view (usp_view),
        .isp_raw  (bank_isp),
        .usp_raw  (bank_usp)
    );

    for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_pwe
        assign plain_we[i] = eff_cr_we && (eff_cr_idx == CR_IDX_W'(CRI_PLAIN + i));
    end

    sbk_plain_store #(.DATA_W(DATA_W), .NUM(NUM_PLAIN)) u_plain (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (plain_we),
        .wdata (eff_cr_wd),
        .q     (plain_q)
    );

    assign mode_user = (mode == STK_USER);

    // Read view of all implemented control registers
    always_comb begin
        cr_view[CRI_PSW] = '0;
        cr_view[CRI_PSW][PSW_BSM] = flags.bsm;
        cr_view[CRI_PSW][PSW_BIE] = flags.bie;
        cr_view[CRI_PSW][PSW_BC]  = flags.bc;
        cr_view[CRI_PSW][PSW_SM]  = mode_user;
        cr_view[CRI_PSW][PSW_IE]  = flags.ie;
        cr_view[CRI_PSW][PSW_C]   = flags.c;
        cr_view[CRI_COND] = DATA_W'(flags.c);
        cr_view[CRI_ISP]  = isp_view;
        cr_view[CRI_USP]  = usp_view;
        for (int i = 0; i < NUM_PLAIN; i++) cr_view[CRI_PLAIN + i] = plain_q[i];
    end

    assign cr_rdata    = (cr_idx < CR_IDX_W'(NUM_CR)) ? cr_view[cr_idx] : '0;
    assign dbg_cr_data = cr_view[dbg_cr_sel];
    assign sp_rdata    = live_sp;

    always_comb begin
        unique case (dbg_kind)
            DK_GR:   dbg_rdata = dbg_sp_hit ? live_sp : gr_ext_rdata;
            DK_CR:   dbg_rdata = dbg_cr_data;
            DK_PC:   dbg_rdata = pc_val;
            DK_ACCL: dbg_rdata = acc_val[DATA_W-1:0];
            DK_ACCH: dbg_rdata = acc_val[2*DATA_W-1:DATA_W];
            default: dbg_rdata = '0;
        endcase
    end

    assign gr_ext_we = dbg_we && (dbg_kind == DK_GR) && !dbg_sp_hit;
    assign pc_we     = dbg_we && (dbg_kind == DK_PC);
    assign accl_we   = dbg_we && (dbg_kind == DK_ACCL);
    assign acch_we   = dbg_we && (dbg_kind == DK_ACCH);

endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CR_IDX_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CR_IDX_W-1:0] cr_idx,
    input logic                cr_we,
    input logic [DATA_W-1:0]   cr_wdata,
    input logic [DATA_W-1:0]   cr_rdata,
    input logic                sp_we,
    input logic [DATA_W-1:0]   sp_rdata,
    input logic                dbg_we,
    input logic                gr_ext_we,
    input logic                pc_we,
    input logic                accl_we,
    input logic                acch_we,
    input logic                mode_user,
    input logic [DATA_W-1:0]   bank_isp,
    input logic [DATA_W-1:0]   bank_usp
);

    logic psw_flip;
    assign psw_flip = cr_we && (cr_idx == '0) && (cr_wdata[7] != mode_user);

    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_idx == '0) |-> (cr_rdata[5:1] == '0 && cr_rdata[13:9] == '0
                            && cr_rdata[DATA_W-1:16] == '0));

    p_cond_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_idx == CR_IDX_W'(1)) |-> (cr_rdata[DATA_W-1:1] == '0));

    p_swap_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_flip && !sp_we && !dbg_we)
        |=> (sp_rdata == ($past(mode_user) ? $past(bank_isp) : $past(bank_usp))));

    p_swap_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
        psw_flip |=> (($past(mode_user) ? bank_usp : bank_isp) == $past(sp_rdata)));

    p_noswap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && cr_idx == '0 && cr_wdata[7] == mode_user && !sp_we && !dbg_we)
        |=> ($stable(sp_rdata) && $stable(bank_isp) && $stable(bank_usp)));

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_we && cr_idx > CR_IDX_W'(6) && !sp_we && !dbg_we)
        |=> ($stable(sp_rdata) && $stable(bank_isp) && $stable(bank_usp)
             && $stable(mode_user)));

    p_exch_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (psw_flip && sp_we)
        |=> (sp_rdata == ($past(mode_user) ? $past(bank_isp) : $past(bank_usp))));

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cr_we && !sp_we && !dbg_we)
        |=> ($stable(sp_rdata) && $stable(mode_user)));

    p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gr_ext_we, pc_we, accl_we, acch_we}));

    p_strobe_needs_we_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_we |-> ($countones({gr_ext_we, pc_we, accl_we, acch_we}) == 0));

endmodule

bind sysreg_bank sysreg_bank_chk #(.DATA_W(DATA_W), .CR_IDX_W(CR_IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cr_idx    (cr_idx),
    .cr_we     (cr_we),
    .cr_wdata  (cr_wdata),
    .cr_rdata  (cr_rdata),
    .sp_we     (sp_we),
    .sp_rdata  (sp_rdata),
    .dbg_we    (dbg_we),
    .gr_ext_we (gr_ext_we),
    .pc_we     (pc_we),
    .accl_we   (accl_we),
    .acch_we   (acch_we),
    .mode_user (mode_user),
    .bank_isp  (bank_isp),
    .bank_usp  (bank_usp)
);

// File: tb/sim_sysreg_bank.sv
module sim_sysreg_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cr_idx = '0;
    logic        cr_we = 1'b0;
    logic [31:0] cr_wdata = '0;
    logic [31:0] cr_rdata;
    logic        sp_we = 1'b0;
    logic [31:0] sp_wdata = '0;
    logic [31:0] sp_rdata;
    logic [4:0]  dbg_num = '0;
    logic        dbg_we = 1'b0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic [31:0] gr_ext_rdata = '0;
    logic [31:0] pc_val = '0;
    logic [63:0] acc_val = '0;
    logic [3:0]  dbg_gr_num;
    logic        gr_ext_we, pc_we, accl_we, acch_we;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    sysreg_bank u0 (.*);

    // Reference state
    logic m_c, m_ie, m_sm, m_bc, m_bie, m_bsm;
    logic [31:0] m_sp, m_isp, m_usp, m_p4, m_p5, m_p6;

    function automatic logic [31:0] m_cr(input int i);
        case (i)
            0: return (32'(m_bsm) << 15) | (32'(m_bie) << 14) | (32'(m_bc) << 8)
                    | (32'(m_sm) << 7) | (32'(m_ie) << 6) | 32'(m_c);
            1: return 32'(m_c);
            2: return m_sm ? m_isp : m_sp;
            3: return m_sm ? m_sp : m_usp;
            4: return m_p4;
            5: return m_p5;
            6: return m_p6;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] m_dbg(input int n);
        if (n < 15) return gr_ext_rdata;
        if (n == 15) return m_sp;
        if (n <= 20) return m_cr(n - 16);
        if (n == 21) return pc_val;
        if (n == 22) return acc_val[31:0];
        if (n == 23) return acc_val[63:32];
        return 32'h0;
    endfunction

    task automatic m_apply(input logic cwe, input int ci, input logic [31:0] cwd,
                           input logic swe, input logic [31:0] swd,
                           input logic dwe, input int dn, input logic [31:0] dwd);
        logic ewe; int ei; logic [31:0] ewd; logic [31:0] nsp; logic nsm;
        ewe = cwe; ei = ci; ewd = cwd;
        if (!cwe && dwe && dn >= 16 && dn <= 20) begin ewe = 1'b1; ei = dn - 16; ewd = dwd; end
        nsp = m_sp;
        if (swe) nsp = swd;
        else if (dwe && dn == 15) nsp = dwd;
        if (ewe) begin
            case (ei)
                0: begin
                    nsm = ewd[7];
                    m_bsm = ewd[15]; m_bie = ewd[14]; m_bc = ewd[8];
                    m_ie = ewd[6]; m_c = ewd[0];
                    if (nsm != m_sm) begin
                        if (m_sm) begin m_usp = m_sp; nsp = m_isp; end
                        else      begin m_isp = m_sp; nsp = m_usp; end
                    end
                    m_sm = nsm;
                end
                1: m_c = ewd[0];
                2: if (!m_sm) nsp = ewd; else m_isp = ewd;
                3: if (m_sm) nsp = ewd; else m_usp = ewd;
                4: m_p4 = ewd;
                5: m_p5 = ewd;
                6: m_p6 = ewd;
                default: ;
            endcase
        end
        m_sp = nsp;
    endtask

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic op(input string tag, input logic cwe, input int ci, input logic [31:0] cwd,
                      input logic swe, input logic [31:0] swd,
                      input logic dwe, input int dn, input logic [31:0] dwd);
        logic [3:0] es;
        @(negedge clk);
        cr_we = cwe; cr_idx = 4'(ci); cr_wdata = cwd;
        sp_we = swe; sp_wdata = swd;
        dbg_we = dwe; dbg_num = 5'(dn); dbg_wdata = dwd;
        gr_ext_rdata = $urandom; pc_val = $urandom; acc_val = {$urandom, $urandom};
        #2;
        check(tag, "cr_rdata", cr_rdata, m_cr(ci));
        check(tag, "sp_rdata", sp_rdata, m_sp);
        check(tag, "dbg_rdata R12", dbg_rdata, m_dbg(dn));
        es = {dwe && dn < 15, dwe && dn == 21, dwe && dn == 22, dwe && dn == 23};
        check(tag, "strobes R13", {28'h0, gr_ext_we, pc_we, accl_we, acch_we}, {28'h0, es});
        if (dn < 15) check(tag, "dbg_gr_num R12", {28'h0, dbg_gr_num}, 32'(dn));
        @(posedge clk);
        m_apply(cwe, ci, cwd, swe, swd, dwe, dn, dwd);
    endtask

    task automatic rd(input string tag, input int ci);
        op(tag, 1'b0, ci, 32'h0, 1'b0, 32'h0, 1'b0, 31, 32'h0);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        {m_c, m_ie, m_sm, m_bc, m_bie, m_bsm} = '0;
        {m_sp, m_isp, m_usp, m_p4, m_p5, m_p6} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 16; i++) rd("R1 reset", i);

        op("R4 sp write", 1'b0, 0, 0, 1'b1, 32'hA0A0_0001, 1'b0, 31, 0);
        rd("R4 alias read", 2);
        op("R4 alias write", 1'b1, 2, 32'hC0C0_0002, 1'b0, 0, 1'b0, 31, 0);
        op("R5 own write", 1'b1, 3, 32'hB0B0_0003, 1'b0, 0, 1'b0, 31, 0);
        rd("R5 own read", 3);
        op("R6 to user", 1'b1, 0, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 31, 0);
        rd("R2 packed", 0);
        rd("R6 isp saved", 2);
        op("R5 alias write", 1'b1, 3, 32'hD0D0_0004, 1'b0, 0, 1'b0, 31, 0);
        op("R7 same mode", 1'b1, 0, 32'h0000_0080, 1'b0, 0, 1'b0, 31, 0);
        rd("R7 after", 0);
        op("R3 c clear", 1'b1, 1, 32'hFFFF_FFFE, 1'b0, 0, 1'b0, 31, 0);
        op("R3 c set", 1'b1, 1, 32'h0000_0001, 1'b0, 0, 1'b0, 31, 0);
        rd("R3 read", 1);
        rd("R3 psw", 0);
        op("R10 to intr", 1'b1, 0, 32'h0000_4101, 1'b1, 32'hEEEE_0005, 1'b0, 31, 0);
        rd("R10 usp saved", 3);
        op("R10 to user", 1'b1, 0, 32'h0000_0080, 1'b1, 32'h1111_0006, 1'b1, 15, 32'h2222_0007);
        rd("R10 isp saved", 2);
        op("R8 cr4", 1'b1, 4, 32'h4444_4444, 1'b0, 0, 1'b0, 31, 0);
        op("R8 cr5", 1'b1, 5, 32'h5555_5555, 1'b0, 0, 1'b0, 31, 0);
        op("R8 cr6", 1'b1, 6, 32'h6666_6666, 1'b0, 0, 1'b0, 31, 0);
        for (int i = 4; i < 7; i++) rd("R8 read", i);
        op("R9 write 9", 1'b1, 9, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 31, 0);
        op("R9 write 15", 1'b1, 15, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 31, 0);
        for (int i = 0; i < 16; i++) rd("R9 read", i);
        for (int n = 0; n < 32; n++) op("R12 sweep", 1'b0, 0, 0, 1'b0, 0, 1'b0, n, 0);
        op("R13 sp port wins", 1'b0, 0, 0, 1'b1, 32'h3333_0008, 1'b1, 15, 32'h9999_0009);
        op("R13 cr port wins", 1'b1, 4, 32'h7777_000A, 1'b0, 0, 1'b1, 20, 32'h8888_000B);
        rd("R13 cr4", 4);
        op("R13 dbg cr write", 1'b0, 0, 0, 1'b0, 0, 1'b1, 18, 32'hABCD_000C);
        rd("R13 cr2", 2);
        op("R13 dbg psw flip", 1'b0, 0, 0, 1'b0, 0, 1'b1, 16, 32'h0000_0000);
        for (int n = 0; n < 32; n++) op("R13 strobes", 1'b0, 0, 0, 1'b0, 0, 1'b1, n, $urandom);

        for (int k = 0; k < 800; k++) begin
            logic cwe, swe, dwe; int ci, dn; logic [31:0] cwd;
            cwe = ($urandom % 3) != 0;
            ci  = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 4);
            cwd = $urandom;
            swe = ($urandom % 2) == 1;
            dwe = ($urandom % 3) == 0;
            dn  = ($urandom % 2 == 0) ? 15 + int'($urandom % 6) : int'($urandom % 32);
            op("R11 random", cwe, ci, cwd, swe, $urandom, dwe, dn, $urandom);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule